// File: doc/BRIEF.md
# Quality-Based Clock Reference Selector

This block decides which of N candidate timing references a clock unit traces. Each candidate brings a health flag, a 4-bit synchronization status code and a priority value. The selected index steers an external clock multiplexer, which lies outside this block. The block also produces two more outputs. The first is a holdover flag, raised when nothing usable remains. The second is the status code to advertise downstream.

Two ranking rules are available. In quality mode the status code decides first and priority breaks ties. The code order here is not numeric. In priority mode only the priority value counts. A force input can pin the selection to one candidate. A per-candidate override can replace the received code with a value set by software. The selection is evaluated again on every clock. When a better reference recovers, the block moves back to it, and every change of index produces a one-cycle event pulse.

Top module: `clkref_select`

## Requirements
- R1: Only status codes 0x0, 0x2, 0x4, 0x8, 0xB and 0xF have meaning. Any other code is treated as 0xF (do-not-use), both for ranking and for the advertised code.
- R2: While reset is low, the outputs are holdover=1, sel_idx=0, out_code=0xB and switch_evt=0. The stored status codes reset to 0x0 (Unknown), so on the first clock after reset the advertised code of a traced source is 0x0.
- R3: With qual_mode=1, a candidate is eligible when src_ok=1, its priority is nonzero and its code is not 0xF. The best code wins, in the order 0x2 > 0x4 > 0x8 > 0xB > 0x0. Equal codes are decided by the larger priority value, and any remaining tie goes to the lowest index.
- R4: With qual_mode=0, a candidate is eligible when src_ok=1 and its priority is nonzero, whatever its code. The largest priority value wins, and ties go to the lowest index.
- R5: A candidate whose priority field is 0 is never chosen by automatic selection.
- R6: While tracing (holdover=0), out_code equals the normalized code of the candidate at sel_idx. In holdover, out_code is 0xB.
- R7: When no candidate is eligible and force is off, holdover goes to 1 and sel_idx keeps its previous value.
- R8: With force_en=1, sel_idx becomes force_idx on the next clock, whatever the ranking. Holdover is then 1 exactly when that candidate's src_ok is 0.
- R9: When ovr_en[i]=1, ovr_code slice i replaces src_code slice i as the candidate's status code.
- R10: Selection is revertive. The outputs register src_ok, priorities, mode and force one clock after they are applied. Codes pass through one more register stage. switch_evt is 1 for exactly the cycle in which sel_idx takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qual_mode | input | 1 | 1: rank by code then priority; 0: priority only |
| src_ok | input | N | Per-candidate health flag |
| src_code | input | 4*N | Received status codes, candidate i at bits 4i+3:4i |
| ovr_en | input | N | Per-candidate code override enable |
| ovr_code | input | 4*N | Override codes, same layout as src_code |
| src_prio | input | PW*N | Priorities, candidate i at bits PW*i+PW-1:PW*i; larger wins, 0 excludes |
| force_en | input | 1 | Force selection to force_idx |
| force_idx | input | IW | Forced candidate index |
| sel_idx | output | IW | Traced candidate index |
| holdover | output | 1 | No reference traced |
| out_code | output | 4 | Status code to advertise |
| switch_evt | output | 1 | One-cycle pulse on index change |

## Verification
The assertions assume that force_idx always names an existing candidate. They also assume that inputs are held at defined values from the first clock on, because several properties look one cycle back at qual_mode, force_en and force_idx. The bench uses the default of four candidates, so every index it can drive is valid. It drives every input to a known value from time zero and changes inputs only on falling edges. It lets each vector settle for three clocks before comparing, which covers the two register stages a code change passes through.

// File: rtl/clkref_select.sv
module clkref_select #(
  parameter int N  = 4,
  parameter int PW = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            qual_mode,
  input  logic [N-1:0]    src_ok,
  input  logic [4*N-1:0]  src_code,
  input  logic [N-1:0]    ovr_en,
  input  logic [4*N-1:0]  ovr_code,
  input  logic [PW*N-1:0] src_prio,
  input  logic            force_en,
  input  logic [IW-1:0]   force_idx,
  output logic [IW-1:0]   sel_idx,
  output logic            holdover,
  output logic [3:0]      out_code,
  output logic            switch_evt
);

  localparam logic [3:0] C_SEC = 4'hB;
  localparam logic [3:0] C_DNU = 4'hF;

  function automatic logic [3:0] norm(input logic [3:0] c);
    case (c)
      4'h0, 4'h2, 4'h4, 4'h8, 4'hB, 4'hF: norm = c;
      default:                           norm = C_DNU;
    endcase
  endfunction

  function automatic logic [2:0] rank(input logic [3:0] c);
    case (c)
      4'h2:    rank = 3'd0;
      4'h4:    rank = 3'd1;
      4'h8:    rank = 3'd2;
      4'hB:    rank = 3'd3;
      4'h0:    rank = 3'd4;
      default: rank = 3'd5;
    endcase
  endfunction

  logic [N-1:0][3:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        code_q[i] <= norm(ovr_en[i] ? ovr_code[i*4 +: 4] : src_code[i*4 +: 4]);
    end
  end

  logic          found;
  logic [IW-1:0] best;
  logic [2:0]    best_rk, rk;
  logic [PW-1:0] best_p, p;
  logic          elig, better;

  always_comb begin
    found   = 1'b0;
    best    = '0;
    best_rk = 3'd7;
    best_p  = '0;
    rk      = '0;
    p       = '0;
    elig    = 1'b0;
    better  = 1'b0;
    for (int i = 0; i < N; i++) begin
      rk   = rank(code_q[i]);
      p    = src_prio[i*PW +: PW];
      elig = src_ok[i] && (p != '0) && !(qual_mode && rk == 3'd5);
      if (!found)        better = 1'b1;
      else if (qual_mode) better = (rk < best_rk) || (rk == best_rk && p > best_p);
      else               better = p > best_p;
      if (elig && better) begin
        found   = 1'b1;
        best    = i[IW-1:0];
        best_rk = rk;
        best_p  = p;
      end
    end
  end

  logic [IW-1:0] nxt_idx;
  logic          nxt_hold;

  always_comb begin
    if (force_en) begin
      nxt_idx  = force_idx;
      nxt_hold = !src_ok[force_idx];
    end else if (found) begin
      nxt_idx  = best;
      nxt_hold = 1'b0;
    end else begin
      nxt_idx  = sel_idx;
      nxt_hold = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx    <= '0;
      holdover   <= 1'b1;
      out_code   <= C_SEC;
      switch_evt <= 1'b0;
    end else begin
      sel_idx    <= nxt_idx;
      holdover   <= nxt_hold;
      out_code   <= nxt_hold ? C_SEC : code_q[nxt_idx];
      switch_evt <= nxt_idx != sel_idx;
    end
  end

endmodule

module clkref_select_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          qual_mode,
  input logic          force_en,
  input logic [IW-1:0] force_idx,
  input logic [IW-1:0] sel_idx,
  input logic          holdover,
  input logic [3:0]    out_code,
  input logic          switch_evt
);

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_code inside {4'h0, 4'h2, 4'h4, 4'h8, 4'hB, 4'hF});

  a_r3_no_dnu_traced: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdover && $past(qual_mode) && !$past(force_en)) |-> out_code != 4'hF);

  a_r6_holdover_sec: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |-> out_code == 4'hB);

  a_r7_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !$past(force_en)) |-> $stable(sel_idx));

  a_r8_force_index: assert property (@(posedge clk) disable iff (!rst_n)
    $past(force_en) |-> sel_idx == $past(force_idx));

  a_r10_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_idx) |-> switch_evt);

  a_r10_pulse_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |-> !$stable(sel_idx));

endmodule

bind clkref_select clkref_select_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .qual_mode(qual_mode), .force_en(force_en),
  .force_idx(force_idx), .sel_idx(sel_idx), .holdover(holdover),
  .out_code(out_code), .switch_evt(switch_evt)
);

// File: tb/clkref_select_bench.sv
module clkref_select_bench;
  localparam int N = 4, PW = 4, IW = 2;

  logic clk = 0, rst_n = 0, qual_mode = 1, force_en = 0;
  logic [N-1:0] src_ok = 4'b0001, ovr_en = '0;
  logic [4*N-1:0] src_code = 16'h0002, ovr_code = '0;
  logic [PW*N-1:0] src_prio = 16'h0001;
  logic [IW-1:0] force_idx = '0, sel_idx;
  logic holdover, switch_evt;
  logic [3:0] out_code;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkref_select #(.N(N), .PW(PW)) u_clkref_select (
    .clk(clk), .rst_n(rst_n), .qual_mode(qual_mode), .src_ok(src_ok),
    .src_code(src_code), .ovr_en(ovr_en), .ovr_code(ovr_code),
    .src_prio(src_prio), .force_en(force_en), .force_idx(force_idx),
    .sel_idx(sel_idx), .holdover(holdover), .out_code(out_code),
    .switch_evt(switch_evt)
  );

  // {mode, ok[3:0], codes i3..i0, prio i3..i0, exp_hold, exp_idx, exp_code}
  localparam logic [43:0] VEC [13] = '{
    {1'b1, 4'hF, 16'hB842, 16'h1111, 1'b0, 2'd0, 4'h2},  // R3 PRC best
    {1'b1, 4'hF, 16'h284B, 16'h1111, 1'b0, 2'd3, 4'h2},  // R3 order is not numeric
    {1'b1, 4'hF, 16'h0B80, 16'h1111, 1'b0, 2'd1, 4'h8},  // R3
    {1'b1, 4'hF, 16'h0BF0, 16'h1111, 1'b0, 2'd2, 4'hB},  // R3 SEC over Unknown, DNU skipped
    {1'b1, 4'hF, 16'hFFFF, 16'h1111, 1'b1, 2'd2, 4'hB},  // R7 all DNU
    {1'b1, 4'hF, 16'h4444, 16'h3551, 1'b0, 2'd1, 4'h4},  // R3 priority then index tie
    {1'b1, 4'hF, 16'h8882, 16'h1110, 1'b0, 2'd1, 4'h8},  // R5 prio 0 PRC ignored
    {1'b0, 4'hF, 16'hFFFF, 16'h2773, 1'b0, 2'd1, 4'hF},  // R4 DNU allowed
    {1'b0, 4'hB, 16'h2222, 16'h9F10, 1'b0, 2'd3, 4'h2},  // R4 faulty top skipped
    {1'b0, 4'h1, 16'h2222, 16'h9F10, 1'b1, 2'd3, 4'hB},  // R5 R7
    {1'b1, 4'hF, 16'h5A0C, 16'h1111, 1'b0, 2'd1, 4'h0},  // R1 illegal codes
    {1'b0, 4'h4, 16'h9999, 16'h1111, 1'b0, 2'd2, 4'hF},  // R1 advertised normalized
    {1'b1, 4'hF, 16'h8882, 16'h1111, 1'b0, 2'd0, 4'h2}   // R10 revert
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    check("R2 reset holdover", holdover, 1);
    check("R2 reset idx", sel_idx, 0);
    check("R2 reset code", out_code, 4'hB);
    check("R2 reset pulse", switch_evt, 0);
    rst_n = 1;
    step(1);
    check("R2 first trace", holdover, 0);
    check("R2 default Unknown", out_code, 4'h0);
    step(1);
    check("R6 traced code", out_code, 4'h2);

    for (int v = 0; v < 13; v++) begin
      {qual_mode, src_ok, src_code, src_prio} = VEC[v][43:7];
      step(3);
      check(qual_mode ? "R3/R6 vec hold" : "R4/R6 vec hold", holdover, VEC[v][6]);
      check(qual_mode ? "R3/R7 vec idx" : "R4/R7 vec idx", sel_idx, VEC[v][5:4]);
      check(qual_mode ? "R3/R6 vec code" : "R4/R6 vec code", out_code, VEC[v][3:0]);
    end

    // R10 switch pulse and revertive return
    qual_mode = 0; src_ok = 4'hF; src_code = 16'h2222; src_prio = 16'h0021;
    step(3);
    check("R10 setup idx", sel_idx, 1);
    src_ok = 4'b1101;
    step(1);
    check("R10 fail idx", sel_idx, 0);
    check("R10 pulse", switch_evt, 1);
    step(1);
    check("R10 pulse one cycle", switch_evt, 0);
    src_ok = 4'hF;
    step(1);
    check("R10 revert idx", sel_idx, 1);
    check("R10 revert pulse", switch_evt, 1);

    // R8 force
    src_code = 16'h4222;
    step(3);
    force_en = 1; force_idx = 2'd3;
    step(1);
    check("R8 forced idx", sel_idx, 3);
    check("R8 forced hold", holdover, 0);
    check("R8 forced code", out_code, 4'h4);
    src_ok = 4'b0111;
    step(1);
    check("R8 forced faulty hold", holdover, 1);
    check("R8 forced faulty idx", sel_idx, 3);
    check("R8 forced faulty code", out_code, 4'hB);
    force_en = 0; src_ok = 4'hF;
    step(1);
    check("R8 release idx", sel_idx, 1);
    check("R8 release hold", holdover, 0);

    // R9 override
    qual_mode = 1; src_code = 16'hBB42; src_prio = 16'h1111;
    ovr_en = 4'b0001; ovr_code = 16'h000F;
    step(3);
    check("R9 override idx", sel_idx, 1);
    check("R9 override code", out_code, 4'h4);
    ovr_code = 16'h0008;
    step(3);
    check("R9 override to SSUB", sel_idx, 1);
    ovr_en = '0;
    step(3);
    check("R9 override off idx", sel_idx, 0);
    check("R9 override off code", out_code, 4'h2);

    finish_run();
  end
endmodule